// File: doc/BRIEF.md
# Front-Panel I/O Port Decoder

This block decodes an 8-bit port address on a small processor's I/O bus, with strobed reads and writes. It owns the front-panel state: three banks of active-low LED latches, a serial and tape output latch, a PROM programming pulse latch and a power-up flag. It also builds the switch/status byte returned to software. Two port addresses go to an external keyboard/display controller. For these the block raises a select, a command/data qualifier and read/write strobes, and it routes the controller's read data back onto the bus.

The block also watches reads of a run of three port addresses. Each such read picks a memory-map variant, and that choice leaves the block only as a sideband code for the memory decoder. All port addresses, bank counts and data widths are parameters.

A cold reset (asynchronous, active low) sets the power-up flag. A warm reset (synchronous, active high) returns every output latch to idle and leaves the power-up flag as it was. Software clears the flag by writing to its port.

Top module: `fpio_decoder`

## Requirements
- R1: A write to port 0, 1 or 2 stores the write data in LED bank 0, 1 or 2 on the next clock edge. `led_n` carries bank b in bits [8b+7:8b]. A bit value of 0 means the LED is lit. The other banks keep their values, and after either reset every bank holds 0xFF.
- R2: A read of port 1 returns the following byte. Bits 7 and 2 are 1. Bit 6 is the power-up flag. Bit 5 is `sw_hex`, bit 4 is `sw_pup` and bit 3 is `sw_exec`. Bit 1 is `tape_in` and bit 0 is `ser_in`.
- R3: A write to port 5 sets `ser_out` from data bit 0 and `tape_out` from data bit 1 on the next edge. After reset `ser_out` is 1 and `tape_out` is 0.
- R4: A read or write of port 3 or 4 raises `kdc_cs`. `kdc_a0` is 1 for port 3 and 0 for port 4. `kdc_rd` follows the read strobe and `kdc_wr` follows the write strobe. A read of either port returns `kdc_rdata`. For every other address all four controller outputs stay 0.
- R5: `pwrup_flag` is 1 after a cold reset. Any write to port 9 clears it. A warm reset and writes to other ports leave it unchanged, and it never rises except through a cold reset.
- R6: A write to port 10 sets `prom_pulse` from data bit 0, and `prom_pulse` is 0 after reset. A read of port 8 returns `prom_rdata`.
- R7: A read of port 5, 6 or 7 sets `map_sel` to 0, 1 or 2 on the next edge and returns 0xFF on the bus. Both resets set `map_sel` to 0.
- R8: A read of any other port returns 0xFF, and `io_rdata` is 0xFF whenever `io_rd` is low.
- R9: A warm reset wins over any write in the same cycle, with one exception: a write to port 9 still clears the flag. During a warm reset every LED latch becomes 0xFF, `ser_out` 1, `tape_out` 0, `prom_pulse` 0 and `map_sel` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_cold_n | input | 1 | Cold reset, asynchronous, active low |
| warm_rst | input | 1 | Warm reset, synchronous, active high |
| io_addr | input | 8 | Port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data |
| sw_exec | input | 1 | Exec/user switch |
| sw_pup | input | 1 | Power-up/reset switch |
| sw_hex | input | 1 | Hex (1) / octal (0) switch |
| tape_in | input | 1 | Tape input level |
| ser_in | input | 1 | Serial input level |
| kdc_rdata | input | 8 | Controller read data |
| prom_rdata | input | 8 | PROM programmer read data |
| led_n | output | 24 | Three active-low LED banks |
| ser_out | output | 1 | Serial output latch |
| tape_out | output | 1 | Tape output latch |
| prom_pulse | output | 1 | PROM programming pulse latch |
| pwrup_flag | output | 1 | Power-up flag |
| map_sel | output | 2 | Memory-map variant code |
| kdc_cs | output | 1 | Controller select |
| kdc_a0 | output | 1 | 1 = command/status, 0 = data |
| kdc_rd | output | 1 | Controller read strobe |
| kdc_wr | output | 1 | Controller write strobe |

## Verification
The bench builds the block with its default parameters: 8-bit data and addresses, three LED banks and three map ports. Those defaults make the address space only 256 entries, so every port address can be read and written in turn. Against a model computed from the requirements, this exposes any stray decode, alias or overlap. All 32 combinations of the five switch and level inputs are swept through the status port, with the power-up flag both set and cleared. Warm reset is driven over a fully non-idle state to show which state it clears and which it keeps.

// File: rtl/fpio_pkg.sv
package fpio_pkg;

   // Decoded single-port hits other than the LED banks and the map run
   typedef struct packed {
      logic stat;
      logic kdc_cmd;
      logic kdc_dat;
      logic tape;
      logic map_any;
      logic prom;
      logic pup;
      logic pulse;
   } fpio_hit_t;

   // Status byte bit positions (read side of the status port)
   localparam int ST_SER   = 0;
   localparam int ST_TAPE  = 1;
   localparam int ST_EXEC  = 3;
   localparam int ST_PUPSW = 4;
   localparam int ST_HEX   = 5;
   localparam int ST_PWRUP = 6;

   // Output latch bit positions in write data
   localparam int WR_SER   = 0;
   localparam int WR_TAPE  = 1;
   localparam int WR_PULSE = 0;

endpackage

// File: rtl/fpio_addr_dec.sv
module fpio_addr_dec
   import fpio_pkg::*;
#(
   parameter int AW           = 8,
   parameter int LED_BANKS    = 3,
   parameter int LED_BASE     = 0,
   parameter int STAT_PORT    = 1,
   parameter int KDC_CMD_PORT = 3,
   parameter int KDC_DAT_PORT = 4,
   parameter int TAPE_PORT    = 5,
   parameter int MAP_BASE     = 5,
   parameter int MAP_PORTS    = 3,
   parameter int MAP_W        = 2,
   parameter int PROM_PORT    = 8,
   parameter int PUP_PORT     = 9,
   parameter int PULSE_PORT   = 10
) (
   input  logic [AW-1:0]        addr,
   output logic [LED_BANKS-1:0] led_hit,
   output fpio_hit_t            hit,
   output logic [MAP_W-1:0]     map_idx
);

   for (genvar b = 0; b < LED_BANKS; b++) begin : g_led_hit
      assign led_hit[b] = (addr == AW'(LED_BASE + b));
   end

   always_comb begin
      hit         = '0;
      hit.stat    = (addr == AW'(STAT_PORT));
      hit.kdc_cmd = (addr == AW'(KDC_CMD_PORT));
      hit.kdc_dat = (addr == AW'(KDC_DAT_PORT));
      hit.tape    = (addr == AW'(TAPE_PORT));
      hit.prom    = (addr == AW'(PROM_PORT));
      hit.pup     = (addr == AW'(PUP_PORT));
      hit.pulse   = (addr == AW'(PULSE_PORT));
      map_idx     = '0;
      for (int j = 0; j < MAP_PORTS; j++) begin
         if (addr == AW'(MAP_BASE + j)) begin
            hit.map_any = 1'b1;
            map_idx     = MAP_W'(j);
         end
      end
   end

endmodule

// File: rtl/fpio_out_regs.sv
module fpio_out_regs
   import fpio_pkg::*;
#(
   parameter int DW        = 8,
   parameter int LED_BANKS = 3,
   parameter int MAP_W     = 2
) (
   input  logic                    clk,
   input  logic                    rst_cold_n,
   input  logic                    warm_rst,
   input  logic                    io_wr,
   input  logic                    io_rd,
   input  logic [DW-1:0]           wdata,
   input  logic [LED_BANKS-1:0]    led_hit,
   input  fpio_hit_t               hit,
   input  logic [MAP_W-1:0]        map_idx,
   output logic [LED_BANKS*DW-1:0] led_n,
   output logic                    ser_out,
   output logic                    tape_out,
   output logic                    prom_pulse,
   output logic                    pwrup_flag,
   output logic [MAP_W-1:0]        map_sel
);

   logic [DW-1:0] led_q [LED_BANKS];

   for (genvar b = 0; b < LED_BANKS; b++) begin : g_led
      always_ff @(posedge clk or negedge rst_cold_n) begin
         if (!rst_cold_n)                  led_q[b] <= '1;
         else if (warm_rst)                led_q[b] <= '1;
         else if (io_wr && led_hit[b])     led_q[b] <= wdata;
      end
      assign led_n[b*DW +: DW] = led_q[b];
   end

   always_ff @(posedge clk or negedge rst_cold_n) begin
      if (!rst_cold_n) begin
         ser_out    <= 1'b1;
         tape_out   <= 1'b0;
         prom_pulse <= 1'b0;
         map_sel    <= '0;
      end else if (warm_rst) begin
         ser_out    <= 1'b1;
         tape_out   <= 1'b0;
         prom_pulse <= 1'b0;
         map_sel    <= '0;
      end else begin
         if (io_wr && hit.tape) begin
            ser_out  <= wdata[WR_SER];
            tape_out <= wdata[WR_TAPE];
         end
         if (io_wr && hit.pulse)   prom_pulse <= wdata[WR_PULSE];
         if (io_rd && hit.map_any) map_sel    <= map_idx;
      end
   end

   // Power-up flag: only a cold reset sets it
   always_ff @(posedge clk or negedge rst_cold_n) begin
      if (!rst_cold_n)           pwrup_flag <= 1'b1;
      else if (io_wr && hit.pup) pwrup_flag <= 1'b0;
   end

endmodule

// File: rtl/fpio_rd_mux.sv
module fpio_rd_mux
   import fpio_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          io_rd,
   input  fpio_hit_t     hit,
   input  logic          pwrup_flag,
   input  logic          sw_exec,
   input  logic          sw_pup,
   input  logic          sw_hex,
   input  logic          tape_in,
   input  logic          ser_in,
   input  logic [DW-1:0] kdc_rdata,
   input  logic [DW-1:0] prom_rdata,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] status;

   always_comb begin
      status           = '1;
      status[ST_PWRUP] = pwrup_flag;
      status[ST_HEX]   = sw_hex;
      status[ST_PUPSW] = sw_pup;
      status[ST_EXEC]  = sw_exec;
      status[ST_TAPE]  = tape_in;
      status[ST_SER]   = ser_in;
   end

   always_comb begin
      rdata = '1;
      if (io_rd) begin
         if (hit.stat)                         rdata = status;
         else if (hit.kdc_cmd || hit.kdc_dat)  rdata = kdc_rdata;
         else if (hit.prom)                    rdata = prom_rdata;
      end
   end

endmodule

// File: rtl/fpio_decoder.sv
module fpio_decoder
   import fpio_pkg::*;
#(
   parameter int DW           = 8,
   parameter int AW           = 8,
   parameter int LED_BANKS    = 3,
   parameter int LED_BASE     = 0,
   parameter int STAT_PORT    = 1,
   parameter int KDC_CMD_PORT = 3,
   parameter int KDC_DAT_PORT = 4,
   parameter int TAPE_PORT    = 5,
   parameter int MAP_BASE     = 5,
   parameter int MAP_PORTS    = 3,
   parameter int PROM_PORT    = 8,
   parameter int PUP_PORT     = 9,
   parameter int PULSE_PORT   = 10,
   localparam int MAP_W       = (MAP_PORTS > 1) ? $clog2(MAP_PORTS) : 1
) (
   input  logic                    clk,
   input  logic                    rst_cold_n,
   input  logic                    warm_rst,
   input  logic [AW-1:0]           io_addr,
   input  logic [DW-1:0]           io_wdata,
   input  logic                    io_wr,
   input  logic                    io_rd,
   output logic [DW-1:0]           io_rdata,
   input  logic                    sw_exec,
   input  logic                    sw_pup,
   input  logic                    sw_hex,
   input  logic                    tape_in,
   input  logic                    ser_in,
   input  logic [DW-1:0]           kdc_rdata,
   input  logic [DW-1:0]           prom_rdata,
   output logic [LED_BANKS*DW-1:0] led_n,
   output logic                    ser_out,
   output logic                    tape_out,
   output logic                    prom_pulse,
   output logic                    pwrup_flag,
   output logic [MAP_W-1:0]        map_sel,
   output logic                    kdc_cs,
   output logic                    kdc_a0,
   output logic                    kdc_rd,
   output logic                    kdc_wr
);

   localparam int NPORTS = 1 << AW;

   if (DW < 8) begin : g_chk_dw
      $error("fpio_decoder: DW must be at least 8");
   end
   if (LED_BANKS < 1 || LED_BASE + LED_BANKS > NPORTS) begin : g_chk_led
      $error("fpio_decoder: LED bank range does not fit the port space");
   end
   if (MAP_PORTS < 1 || MAP_BASE + MAP_PORTS > NPORTS) begin : g_chk_map
      $error("fpio_decoder: map port range does not fit the port space");
   end
   if (PULSE_PORT >= NPORTS || PUP_PORT >= NPORTS || PROM_PORT >= NPORTS ||
       KDC_CMD_PORT >= NPORTS || KDC_DAT_PORT >= NPORTS || STAT_PORT >= NPORTS ||
       TAPE_PORT >= NPORTS) begin : g_chk_ports
      $error("fpio_decoder: a port address exceeds the port space");
   end

   logic [LED_BANKS-1:0] led_hit;
   fpio_hit_t            hit;
   logic [MAP_W-1:0]     map_idx;
   logic                 kdc_hit;

   fpio_addr_dec #(
      .AW(AW), .LED_BANKS(LED_BANKS), .LED_BASE(LED_BASE), .STAT_PORT(STAT_PORT),
      .KDC_CMD_PORT(KDC_CMD_PORT), .KDC_DAT_PORT(KDC_DAT_PORT), .TAPE_PORT(TAPE_PORT),
      .MAP_BASE(MAP_BASE), .MAP_PORTS(MAP_PORTS), .MAP_W(MAP_W), .PROM_PORT(PROM_PORT),
      .PUP_PORT(PUP_PORT), .PULSE_PORT(PULSE_PORT)
   ) u_dec (
      .addr(io_addr), .led_hit(led_hit), .hit(hit), .map_idx(map_idx)
   );

   fpio_out_regs #(.DW(DW), .LED_BANKS(LED_BANKS), .MAP_W(MAP_W)) u_regs (
      .clk(clk), .rst_cold_n(rst_cold_n), .warm_rst(warm_rst),
      .io_wr(io_wr), .io_rd(io_rd), .wdata(io_wdata),
      .led_hit(led_hit), .hit(hit), .map_idx(map_idx),
      .led_n(led_n), .ser_out(ser_out), .tape_out(tape_out),
      .prom_pulse(prom_pulse), .pwrup_flag(pwrup_flag), .map_sel(map_sel)
   );

   fpio_rd_mux #(.DW(DW)) u_rd (
      .io_rd(io_rd), .hit(hit), .pwrup_flag(pwrup_flag),
      .sw_exec(sw_exec), .sw_pup(sw_pup), .sw_hex(sw_hex),
      .tape_in(tape_in), .ser_in(ser_in),
      .kdc_rdata(kdc_rdata), .prom_rdata(prom_rdata), .rdata(io_rdata)
   );

   assign kdc_hit = hit.kdc_cmd | hit.kdc_dat;
   assign kdc_cs  = kdc_hit & (io_rd | io_wr);
   assign kdc_a0  = hit.kdc_cmd & (io_rd | io_wr);
   assign kdc_rd  = kdc_hit & io_rd;
   assign kdc_wr  = kdc_hit & io_wr;

endmodule

// File: rtl/fpio_decoder_chk.sv
module fpio_decoder_chk #(
   parameter int DW           = 8,
   parameter int AW           = 8,
   parameter int LED_BANKS    = 3,
   parameter int LED_BASE     = 0,
   parameter int KDC_CMD_PORT = 3,
   parameter int KDC_DAT_PORT = 4,
   parameter int MAP_BASE     = 5,
   parameter int MAP_PORTS    = 3,
   parameter int MAP_W        = 2,
   parameter int PUP_PORT     = 9
) (
   input logic                    clk,
   input logic                    rst_cold_n,
   input logic                    warm_rst,
   input logic [AW-1:0]           io_addr,
   input logic [DW-1:0]           io_wdata,
   input logic                    io_wr,
   input logic                    io_rd,
   input logic [DW-1:0]           io_rdata,
   input logic [LED_BANKS*DW-1:0] led_n,
   input logic                    ser_out,
   input logic                    tape_out,
   input logic                    prom_pulse,
   input logic                    pwrup_flag,
   input logic [MAP_W-1:0]        map_sel,
   input logic                    kdc_cs
);

   assert_led_hold_R1: assert property (@(posedge clk) disable iff (!rst_cold_n)
      (!io_wr && !warm_rst) |=> $stable(led_n));

   assert_led_write_R1: assert property (@(posedge clk) disable iff (!rst_cold_n)
      (io_wr && io_addr == AW'(LED_BASE) && !warm_rst) |=> (led_n[DW-1:0] == $past(io_wdata)));

   assert_kdc_sel_R4: assert property (@(posedge clk) disable iff (!rst_cold_n)
      kdc_cs |-> ((io_rd || io_wr) &&
                  (io_addr == AW'(KDC_CMD_PORT) || io_addr == AW'(KDC_DAT_PORT))));

   assert_pup_clear_R5: assert property (@(posedge clk) disable iff (!rst_cold_n)
      (io_wr && io_addr == AW'(PUP_PORT)) |=> !pwrup_flag);

   assert_pup_no_rise_R5: assert property (@(posedge clk) disable iff (!rst_cold_n)
      !$rose(pwrup_flag));

   assert_map_pick_R7: assert property (@(posedge clk) disable iff (!rst_cold_n)
      (io_rd && io_addr == AW'(MAP_BASE + MAP_PORTS - 1) && !warm_rst)
      |=> (map_sel == MAP_W'(MAP_PORTS - 1)));

   assert_idle_bus_R8: assert property (@(posedge clk) disable iff (!rst_cold_n)
      !io_rd |-> (io_rdata == '1));

   assert_warm_idle_R9: assert property (@(posedge clk) disable iff (!rst_cold_n)
      warm_rst |=> (led_n == '1 && ser_out && !tape_out && !prom_pulse && map_sel == '0));

   assert_warm_keep_R9: assert property (@(posedge clk) disable iff (!rst_cold_n)
      (warm_rst && !(io_wr && io_addr == AW'(PUP_PORT))) |=> $stable(pwrup_flag));

endmodule

bind fpio_decoder fpio_decoder_chk #(
   .DW(DW), .AW(AW), .LED_BANKS(LED_BANKS), .LED_BASE(LED_BASE),
   .KDC_CMD_PORT(KDC_CMD_PORT), .KDC_DAT_PORT(KDC_DAT_PORT),
   .MAP_BASE(MAP_BASE), .MAP_PORTS(MAP_PORTS), .MAP_W(MAP_W), .PUP_PORT(PUP_PORT)
) u_chk (
   .clk(clk), .rst_cold_n(rst_cold_n), .warm_rst(warm_rst), .io_addr(io_addr),
   .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
   .led_n(led_n), .ser_out(ser_out), .tape_out(tape_out), .prom_pulse(prom_pulse),
   .pwrup_flag(pwrup_flag), .map_sel(map_sel), .kdc_cs(kdc_cs)
);

// File: tb/fpio_decoder_bench.sv
module fpio_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_cold_n = 1'b0;
   logic        warm_rst = 1'b0;
   logic [7:0]  io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_rdata;
   logic        sw_exec = 1'b1, sw_pup = 1'b0, sw_hex = 1'b1, tape_in = 1'b1, ser_in = 1'b0;
   logic [7:0]  kdc_rdata = 8'h96;
   logic [7:0]  prom_rdata = 8'h3C;
   logic [23:0] led_n;
   logic        ser_out, tape_out, prom_pulse, pwrup_flag;
   logic [1:0]  map_sel;
   logic        kdc_cs, kdc_a0, kdc_rd, kdc_wr;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference model state
   logic [7:0] m_led [3];
   logic       m_ser, m_tape, m_pulse, m_pup;
   logic [1:0] m_map;

   always #10 clk = ~clk;

   fpio_decoder u_fpio_decoder (
      .clk(clk), .rst_cold_n(rst_cold_n), .warm_rst(warm_rst),
      .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
      .io_rdata(io_rdata), .sw_exec(sw_exec), .sw_pup(sw_pup), .sw_hex(sw_hex),
      .tape_in(tape_in), .ser_in(ser_in), .kdc_rdata(kdc_rdata), .prom_rdata(prom_rdata),
      .led_n(led_n), .ser_out(ser_out), .tape_out(tape_out), .prom_pulse(prom_pulse),
      .pwrup_flag(pwrup_flag), .map_sel(map_sel),
      .kdc_cs(kdc_cs), .kdc_a0(kdc_a0), .kdc_rd(kdc_rd), .kdc_wr(kdc_wr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_idle();
      for (int b = 0; b < 3; b++) m_led[b] = 8'hFF;
      m_ser = 1'b1; m_tape = 1'b0; m_pulse = 1'b0; m_map = 2'd0;
   endtask

   function automatic logic [7:0] exp_read(input logic [7:0] a);
      if (a == 8'd1) return {1'b1, m_pup, sw_hex, sw_pup, sw_exec, 1'b1, tape_in, ser_in};
      if (a == 8'd3 || a == 8'd4) return kdc_rdata;
      if (a == 8'd8) return prom_rdata;
      return 8'hFF;
   endfunction

   task automatic chk_state(input string tag);
      chk({tag, " R1 led_n"}, {8'h0, led_n}, {8'h0, m_led[2], m_led[1], m_led[0]});
      chk({tag, " R3 ser_out"}, {31'h0, ser_out}, {31'h0, m_ser});
      chk({tag, " R3 tape_out"}, {31'h0, tape_out}, {31'h0, m_tape});
      chk({tag, " R5 pwrup_flag"}, {31'h0, pwrup_flag}, {31'h0, m_pup});
      chk({tag, " R6 prom_pulse"}, {31'h0, prom_pulse}, {31'h0, m_pulse});
      chk({tag, " R7 map_sel"}, {30'h0, map_sel}, {30'h0, m_map});
   endtask

   task automatic cold_reset();
      @(negedge clk); rst_cold_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_cold_n = 1'b1;
      model_idle(); m_pup = 1'b1;
   endtask

   task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
      #1;
      chk("R4 kdc_wr", {31'h0, kdc_wr}, {31'h0, (a == 8'd3 || a == 8'd4)});
      chk("R4 kdc_cs on write", {31'h0, kdc_cs}, {31'h0, (a == 8'd3 || a == 8'd4)});
      @(negedge clk); io_wr = 1'b0;
      if (a < 8'd3) m_led[a[1:0]] = d;
      if (a == 8'd5) begin m_ser = d[0]; m_tape = d[1]; end
      if (a == 8'd9) m_pup = 1'b0;
      if (a == 8'd10) m_pulse = d[0];
   endtask

   task automatic do_rd(input logic [7:0] a);
      @(negedge clk); io_addr = a; io_rd = 1'b1;
      #1;
      chk($sformatf("R2/R4/R6/R8 rdata port %0d", a), {24'h0, io_rdata}, {24'h0, exp_read(a)});
      chk("R4 kdc_cs", {31'h0, kdc_cs}, {31'h0, (a == 8'd3 || a == 8'd4)});
      chk("R4 kdc_a0", {31'h0, kdc_a0}, {31'h0, (a == 8'd3)});
      chk("R4 kdc_rd", {31'h0, kdc_rd}, {31'h0, (a == 8'd3 || a == 8'd4)});
      @(negedge clk); io_rd = 1'b0;
      if (a >= 8'd5 && a <= 8'd7) m_map = 2'(a - 8'd5);
      #1;
      chk("R8 idle bus", {24'h0, io_rdata}, 32'hFF);
   endtask

   initial begin
      model_idle(); m_pup = 1'b1;
      cold_reset();
      @(negedge clk);
      chk_state("reset");

      // exhaustive read sweep, power-up flag set
      for (int a = 0; a < 256; a++) begin
         do_rd(8'(a));
         chk_state("read sweep");
      end

      // status port over every switch/level combination
      for (int s = 0; s < 32; s++) begin
         {sw_exec, sw_pup, sw_hex, tape_in, ser_in} = 5'(s);
         do_rd(8'd1);
      end

      // exhaustive write sweep (port 9 clears the flag part-way)
      for (int a = 0; a < 256; a++) begin
         do_wr(8'(a), 8'(a) ^ 8'hA5);
         chk_state("write sweep");
      end

      // walking zero per LED bank, each lit bit alone
      for (int b = 0; b < 3; b++)
         for (int i = 0; i < 8; i++) begin
            do_wr(8'(b), ~(8'h1 << i));
            chk_state("R1 walking");
         end

      // status port with flag cleared
      for (int s = 0; s < 32; s++) begin
         {sw_exec, sw_pup, sw_hex, tape_in, ser_in} = 5'(s);
         do_rd(8'd1);
      end

      // R9 warm reset over non-idle state, flag set
      cold_reset();
      do_wr(8'd0, 8'h12); do_wr(8'd1, 8'h34); do_wr(8'd2, 8'h56);
      do_wr(8'd5, 8'h02); do_wr(8'd10, 8'h01); do_rd(8'd7);
      chk_state("R9 before warm");
      @(negedge clk); warm_rst = 1'b1; io_wr = 1'b1; io_addr = 8'd1; io_wdata = 8'h00;
      @(negedge clk); warm_rst = 1'b0; io_wr = 1'b0;
      model_idle();
      chk_state("R9 after warm");

      // R5: writes elsewhere never set it again once cleared
      do_wr(8'd9, 8'h00);
      chk_state("R5 cleared");
      do_wr(8'd8, 8'hFF); do_wr(8'd11, 8'hFF);
      @(negedge clk); warm_rst = 1'b1;
      @(negedge clk); warm_rst = 1'b0;
      chk_state("R5 stays clear");
      cold_reset();
      @(negedge clk);
      chk_state("R5 cold sets");

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule